// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Element

This block multiplies an `A_W`-bit operand by a `B_W`-bit operand and folds the product into a wide running sum of `A_W+B_W+GUARD` bits. The product is `A_W+B_W` bits wide. The accumulator grows by `GUARD` extra bits, 16 by default. At run time each beat chooses three things: two's-complement or unsigned operands, whether the product is added or subtracted, and whether the running sum is replaced by a supplied load value. A sticky flag reports when the sum has left the range that the current mode can represent.

Each beat passes through up to three stages. The operand/input stage is optional and so is the product pipeline stage. The accumulator register is always present. The per-beat controls and the load value travel in lock-step with the operands through whichever stages are built, so a beat's mode always reaches the accumulator with that beat's own product.

The operand input registers double as shift chains. Either operand register can take its next value from a neighbour's shift-out instead of its parallel input, so several elements can pass operands along a row. Every stage group takes its clock enable and its synchronous clear from a four-entry bank, and the choice of entry is fixed per stage by a parameter.

Top module: `mac_element`

## Requirements
- R1: With `is_signed`=0, both operands are treated as unsigned. The product is zero-extended and added to `acc` when `sub`=0, or subtracted when `sub`=1 (R3).
- R2: With `is_signed`=1, both operands are treated as two's complement. The product is sign-extended before it is added or subtracted.
- R3: `sub`=1 makes the accumulator take `acc - product`. `sub`=0 makes it take `acc + product`.
- R4: A beat with `load`=1 sets `acc` to that beat's `load_val` and clears `ovf`. The beat's product is discarded.
- R5: `ovf` is set in two cases. In signed mode, the result's sign disagrees with the true signed result. In unsigned mode, an add carries out or a subtract borrows. Once set, `ovf` stays set until a load, a clear or reset.
- R6: With both optional stages built, a beat driven before clock edge k updates `acc` at edge k+2. With both stages bypassed, it updates `acc` at edge k. In both cases the beat's own controls and load value are used.
- R7: While a stage's selected clock-enable bank bit is 0, that stage holds its contents. This applies to the operand stage (bank entry `IN_CE_SEL`), the pipeline stage and the accumulator with `ovf`.
- R8: A 1 on a stage's selected clear bank bit zeroes that stage at the next edge, whatever its clock enable. For the accumulator stage this zeroes `acc` and `ovf`.
- R9: `a_sout`/`b_sout` carry the operand register contents. With `a_chain`/`b_chain`=1, the operand register loads from `a_sin`/`b_sin` instead of `a_in`/`b_in`.
- R10: While `rst_n` is low, `acc`, `ovf`, `a_sout` and `b_sout` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_bank | input | 4 | Clock-enable bank; each stage uses one entry |
| clr_bank | input | 4 | Synchronous clear bank; each stage uses one entry |
| a_in | input | A_W | Parallel multiplicand |
| b_in | input | B_W | Parallel multiplier |
| a_sin | input | A_W | Multiplicand shift-chain input |
| b_sin | input | B_W | Multiplier shift-chain input |
| a_chain | input | 1 | Multiplicand register loads from `a_sin` |
| b_chain | input | 1 | Multiplier register loads from `b_sin` |
| is_signed | input | 1 | Operands are two's complement for this beat |
| sub | input | 1 | Subtract the product for this beat |
| load | input | 1 | Replace the accumulator for this beat |
| load_val | input | A_W+B_W+GUARD | Value written on a load beat |
| a_sout | output | A_W | Multiplicand shift-chain output |
| b_sout | output | B_W | Multiplier shift-chain output |
| acc | output | A_W+B_W+GUARD | Accumulator |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench uses a 4x4-bit element with two guard bits. It streams every operand pair under all four pairings of signed/unsigned with add/subtract, and inserts load beats periodically. A fully pipelined copy and a fully bypassed copy run side by side, and both are compared with an arithmetic model every cycle. That separates sign extension from zero extension, add from subtract, and the beat-to-stage alignment of the controls. The narrow accumulator overflows often, which exercises the sticky flag and its clearing by loads. Directed sequences then freeze the enable bank, pulse individual clear entries and route operands through the shift inputs. Together these show which stage each bank entry governs.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef struct packed {
    logic is_signed;
    logic sub;
    logic load;
  } mac_ctrl_t;

  localparam int CTRL_W = 3;
  localparam int BANK_N = 4;

endpackage

// File: rtl/mac_stage.sv
module mac_stage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nxt;

      always_comb begin
        q_nxt = q_r;
        if (clr)     q_nxt = '0;
        else if (ce) q_nxt = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      assign q = q_r;

      assert_stage_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !clr) |=> $stable(q_r));

      assert_stage_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q_r == '0));
    end else begin : g_wire
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int A_W = 9,
  parameter int B_W = 9
) (
  input  logic               is_signed,
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  output logic [A_W+B_W-1:0] p
);

  localparam int P_W = A_W + B_W;

  logic signed [A_W:0]   a_x;
  logic signed [B_W:0]   b_x;
  logic signed [P_W+1:0] p_full;

  always_comb begin
    a_x    = {is_signed & a[A_W-1], a};
    b_x    = {is_signed & b[B_W-1], b};
    p_full = a_x * b_x;
    p      = p_full[P_W-1:0];
  end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int P_W   = 18,
  parameter int GUARD = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic                 clr,
  input  mac_pkg::mac_ctrl_t   ctrl,
  input  logic [P_W-1:0]       prod,
  input  logic [P_W+GUARD-1:0] load_val,
  output logic [P_W+GUARD-1:0] acc,
  output logic                 ovf
);

  localparam int ACC_W = P_W + GUARD;
  localparam int MSB   = ACC_W - 1;

  logic [ACC_W-1:0] acc_r, acc_nxt, p_ext;
  logic [ACC_W:0]   sum_ext;
  logic             ovf_r, ovf_nxt, step_ovf;

  always_comb begin
    p_ext = ctrl.is_signed ? {{GUARD{prod[P_W-1]}}, prod} : {{GUARD{1'b0}}, prod};
    if (ctrl.sub) sum_ext = {1'b0, acc_r} - {1'b0, p_ext};
    else          sum_ext = {1'b0, acc_r} + {1'b0, p_ext};

    if (ctrl.is_signed)
      step_ovf = (ctrl.sub ? (acc_r[MSB] != p_ext[MSB]) : (acc_r[MSB] == p_ext[MSB]))
                 && (sum_ext[MSB] != acc_r[MSB]);
    else
      step_ovf = sum_ext[ACC_W];

    acc_nxt = acc_r;
    ovf_nxt = ovf_r;
    if (clr) begin
      acc_nxt = '0;
      ovf_nxt = 1'b0;
    end else if (ce) begin
      if (ctrl.load) begin
        acc_nxt = load_val;
        ovf_nxt = 1'b0;
      end else begin
        acc_nxt = sum_ext[ACC_W-1:0];
        ovf_nxt = ovf_r | step_ovf;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_r <= '0;
      ovf_r <= 1'b0;
    end else begin
      acc_r <= acc_nxt;
      ovf_r <= ovf_nxt;
    end
  end

  assign acc = acc_r;
  assign ovf = ovf_r;

  assert_acc_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !clr) |=> ($stable(acc_r) && $stable(ovf_r)));

  assert_acc_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_r == '0 && !ovf_r));

  assert_load_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !clr && ctrl.load) |=> (acc_r == $past(load_val) && !ovf_r));

  assert_ovf_sticky_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_r && !clr && !(ce && ctrl.load)) |=> ovf_r);

endmodule

// File: rtl/mac_element.sv
module mac_element #(
  parameter int A_W          = 9,
  parameter int B_W          = 9,
  parameter int GUARD        = 16,
  parameter bit IN_REG       = 1'b1,
  parameter bit PIPE_REG     = 1'b1,
  parameter int IN_CE_SEL    = 0,
  parameter int PIPE_CE_SEL  = 0,
  parameter int ACC_CE_SEL   = 0,
  parameter int IN_CLR_SEL   = 0,
  parameter int PIPE_CLR_SEL = 0,
  parameter int ACC_CLR_SEL  = 0,
  localparam int P_W   = A_W + B_W,
  localparam int ACC_W = P_W + GUARD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ce_bank,
  input  logic [3:0]       clr_bank,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  input  logic [A_W-1:0]   a_sin,
  input  logic [B_W-1:0]   b_sin,
  input  logic             a_chain,
  input  logic             b_chain,
  input  logic             is_signed,
  input  logic             sub,
  input  logic             load,
  input  logic [ACC_W-1:0] load_val,
  output logic [A_W-1:0]   a_sout,
  output logic [B_W-1:0]   b_sout,
  output logic [ACC_W-1:0] acc,
  output logic             ovf
);

  import mac_pkg::*;

  localparam int SIDE_W = CTRL_W + ACC_W;

  logic [A_W-1:0]    a_d, a_q;
  logic [B_W-1:0]    b_d, b_q;
  mac_ctrl_t         ctrl_in, ctrl_s1, ctrl_s2;
  logic [ACC_W-1:0]  lv_s1, lv_s2;
  logic [SIDE_W-1:0] side_s1, side_s2;
  logic [P_W-1:0]    prod_s1, prod_s2;
  logic [P_W+SIDE_W-1:0] pipe_q;

  always_comb begin
    a_d     = a_chain ? a_sin : a_in;
    b_d     = b_chain ? b_sin : b_in;
    ctrl_in = '{is_signed: is_signed, sub: sub, load: load};
  end

  mac_stage #(.W(A_W), .EN(IN_REG)) u_a_reg (
    .clk(clk), .rst_n(rst_n), .ce(ce_bank[IN_CE_SEL]), .clr(clr_bank[IN_CLR_SEL]),
    .d(a_d), .q(a_q)
  );

  mac_stage #(.W(B_W), .EN(IN_REG)) u_b_reg (
    .clk(clk), .rst_n(rst_n), .ce(ce_bank[IN_CE_SEL]), .clr(clr_bank[IN_CLR_SEL]),
    .d(b_d), .q(b_q)
  );

  mac_stage #(.W(SIDE_W), .EN(IN_REG)) u_side_in (
    .clk(clk), .rst_n(rst_n), .ce(ce_bank[IN_CE_SEL]), .clr(clr_bank[IN_CLR_SEL]),
    .d({ctrl_in, load_val}), .q(side_s1)
  );

  assign ctrl_s1 = mac_ctrl_t'(side_s1[SIDE_W-1:ACC_W]);
  assign lv_s1   = side_s1[ACC_W-1:0];

  mac_mult #(.A_W(A_W), .B_W(B_W)) u_mult (
    .is_signed(ctrl_s1.is_signed), .a(a_q), .b(b_q), .p(prod_s1)
  );

  mac_stage #(.W(P_W + SIDE_W), .EN(PIPE_REG)) u_pipe (
    .clk(clk), .rst_n(rst_n), .ce(ce_bank[PIPE_CE_SEL]), .clr(clr_bank[PIPE_CLR_SEL]),
    .d({prod_s1, ctrl_s1, lv_s1}), .q(pipe_q)
  );

  assign prod_s2 = pipe_q[P_W+SIDE_W-1:SIDE_W];
  assign side_s2 = pipe_q[SIDE_W-1:0];
  assign ctrl_s2 = mac_ctrl_t'(side_s2[SIDE_W-1:ACC_W]);
  assign lv_s2   = side_s2[ACC_W-1:0];

  mac_accum #(.P_W(P_W), .GUARD(GUARD)) u_accum (
    .clk(clk), .rst_n(rst_n), .ce(ce_bank[ACC_CE_SEL]), .clr(clr_bank[ACC_CLR_SEL]),
    .ctrl(ctrl_s2), .prod(prod_s2), .load_val(lv_s2), .acc(acc), .ovf(ovf)
  );

  assign a_sout = a_q;
  assign b_sout = b_q;

endmodule

// File: tb/sim_mac_element.sv
module sim_mac_element;

  localparam int AW = 4, BW = 4, GW = 2, CW = AW + BW + GW;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [BW-1:0] b;
    logic          s;
    logic          sb;
    logic          ld;
    logic [CW-1:0] lv;
  } stim_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ce_bank = 4'hF, clr_bank = 4'h0;
  logic [AW-1:0] a_in = '0, a_sin = '0;
  logic [BW-1:0] b_in = '0, b_sin = '0;
  logic a_chain = 1'b0, b_chain = 1'b0;
  logic is_signed = 1'b0, sub = 1'b0, load = 1'b0;
  logic [CW-1:0] load_val = '0;
  logic [AW-1:0] a_sout0, a_sout1;
  logic [BW-1:0] b_sout0, b_sout1;
  logic [CW-1:0] acc0, acc1;
  logic ovf0, ovf1;

  int vec = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mac_element #(.A_W(AW), .B_W(BW), .GUARD(GW), .IN_REG(1'b1), .PIPE_REG(1'b1),
    .IN_CE_SEL(0), .PIPE_CE_SEL(1), .ACC_CE_SEL(2),
    .IN_CLR_SEL(0), .PIPE_CLR_SEL(1), .ACC_CLR_SEL(3)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_bank(ce_bank), .clr_bank(clr_bank),
    .a_in(a_in), .b_in(b_in), .a_sin(a_sin), .b_sin(b_sin),
    .a_chain(a_chain), .b_chain(b_chain), .is_signed(is_signed), .sub(sub),
    .load(load), .load_val(load_val), .a_sout(a_sout0), .b_sout(b_sout0),
    .acc(acc0), .ovf(ovf0));

  mac_element #(.A_W(AW), .B_W(BW), .GUARD(GW), .IN_REG(1'b0), .PIPE_REG(1'b0),
    .IN_CE_SEL(0), .PIPE_CE_SEL(1), .ACC_CE_SEL(2),
    .IN_CLR_SEL(0), .PIPE_CLR_SEL(1), .ACC_CLR_SEL(3)) u1 (
    .clk(clk), .rst_n(rst_n), .ce_bank(ce_bank), .clr_bank(clr_bank),
    .a_in(a_in), .b_in(b_in), .a_sin(a_sin), .b_sin(b_sin),
    .a_chain(a_chain), .b_chain(b_chain), .is_signed(is_signed), .sub(sub),
    .load(load), .load_val(load_val), .a_sout(a_sout1), .b_sout(b_sout1),
    .acc(acc1), .ovf(ovf1));

  task automatic chk(string tag, string what, int act, int exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic stim_t mk(int a, int b, bit s, bit sb, bit ld, int lv);
    stim_t x;
    x.a = a[AW-1:0]; x.b = b[BW-1:0]; x.s = s; x.sb = sb; x.ld = ld; x.lv = lv[CW-1:0];
    return x;
  endfunction

  // arithmetic model of one accumulator update
  function automatic void model(inout logic [CW-1:0] m, inout logic mo, input stim_t x);
    int p, r, sa, sb_v, sm;
    if (x.ld) begin
      m = x.lv; mo = 1'b0;
    end else if (x.s) begin
      sa   = x.a[AW-1] ? int'(x.a) - (1 << AW) : int'(x.a);
      sb_v = x.b[BW-1] ? int'(x.b) - (1 << BW) : int'(x.b);
      sm   = m[CW-1] ? int'(m) - (1 << CW) : int'(m);
      p = sa * sb_v;
      r = x.sb ? sm - p : sm + p;
      if (r > (1 << (CW-1)) - 1 || r < -(1 << (CW-1))) mo = 1'b1;
      m = r[CW-1:0];
    end else begin
      p = int'(x.a) * int'(x.b);
      r = x.sb ? int'(m) - p : int'(m) + p;
      if (r > (1 << CW) - 1 || r < 0) mo = 1'b1;
      m = r[CW-1:0];
    end
  endfunction

  task automatic put(stim_t x, logic [3:0] cev, logic [3:0] clrv,
                     logic ach, logic bch, int as, int bs);
    @(negedge clk);
    a_in = x.a; b_in = x.b; is_signed = x.s; sub = x.sb; load = x.ld; load_val = x.lv;
    ce_bank = cev; clr_bank = clrv; a_chain = ach; b_chain = bch;
    a_sin = as[AW-1:0]; b_sin = bs[BW-1:0];
  endtask

  stim_t hist [0:2];
  logic [CW-1:0] m0 = '0, m1 = '0;
  logic o0 = 1'b0, o1 = 1'b0;

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      vec++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) hist[k] = '0;
    repeat (3) @(negedge clk);
    chk("R10", "acc in reset", int'(acc0), 0);
    chk("R10", "ovf in reset", int'(ovf0), 0);
    chk("R10", "a_sout in reset", int'(a_sout0), 0);
    chk("R10", "b_sout in reset", int'(b_sout0), 0);
    rst_n = 1'b1;

    // sweep: every operand pair in each mode pairing, with periodic loads
    for (int s = 0; s < 2; s++) begin
      for (int sbv = 0; sbv < 2; sbv++) begin
        for (int i = 0; i < 256; i++) begin
          stim_t x;
          string t0;
          x = mk(i >> 4, i & 15, s[0], sbv[0], (i % 37) == 5, (i * 29 + s * 100 + sbv * 7) % 1024);
          put(x, 4'hF, 4'h0, 1'b0, 1'b0, 0, 0);
          model(m0, o0, hist[2]);
          model(m1, o1, hist[0]);
          t0 = hist[2].ld ? "R4" : (hist[2].s ? (hist[2].sb ? "R2/R3" : "R2") : (hist[2].sb ? "R1/R3" : "R1"));
          chk(t0, "acc piped", int'(acc0), int'(m0));
          chk("R5", "ovf piped", int'(ovf0), int'(o0));
          chk("R6", "acc bypassed", int'(acc1), int'(m1));
          chk("R6", "ovf bypassed", int'(ovf1), int'(o1));
          hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = x;
        end
      end
    end

    // R7: bank freeze holds every stage of u0
    put(mk(0, 0, 0, 0, 1, 7), 4'hF, 4'h0, 0, 0, 0, 0);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    put(mk(3, 3, 0, 0, 0, 0), 4'h0, 4'h0, 0, 0, 0, 0);
    chk("R4", "acc after load", int'(acc0), 7);
    for (int k = 0; k < 4; k++) begin
      put(mk(3, 3, 0, 0, 0, 0), 4'h0, 4'h0, 0, 0, 0, 0);
      chk("R7", "acc frozen", int'(acc0), 7);
    end
    for (int k = 0; k < 4; k++) begin
      put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
      chk("R7", "frozen operands never captured", int'(acc0), 7);
    end

    // R5: unsigned borrow sets a sticky flag
    put(mk(1, 15, 0, 1, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    chk("R5", "acc after borrow", int'(acc0), 1016);
    chk("R5", "ovf on borrow", int'(ovf0), 1);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    chk("R5", "ovf sticky", int'(ovf0), 1);

    // R8: accumulator clear wins over a low clock enable
    put(mk(0, 0, 0, 0, 0, 0), 4'b1011, 4'b1000, 0, 0, 0, 0);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    chk("R8", "acc cleared", int'(acc0), 0);
    chk("R8", "ovf cleared", int'(ovf0), 0);

    // R9: operands taken from the shift inputs
    put(mk(0, 0, 0, 0, 1, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    put(mk(1, 1, 0, 0, 0, 0), 4'hF, 4'h0, 1, 1, 5, 3);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    chk("R9", "a_sout from chain", int'(a_sout0), 5);
    chk("R9", "b_sout from chain", int'(b_sout0), 3);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    chk("R9", "acc before chained beat", int'(acc0), 0);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    chk("R9", "chained product", int'(acc0), 15);

    // R8: input-group clear zeroes the operand register
    put(mk(6, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    put(mk(6, 0, 0, 0, 0, 0), 4'hF, 4'b0001, 0, 0, 0, 0);
    chk("R9", "a_sout parallel", int'(a_sout0), 6);
    put(mk(0, 0, 0, 0, 0, 0), 4'hF, 4'h0, 0, 0, 0, 0);
    chk("R8", "input register cleared", int'(a_sout0), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule